// File: doc/BRIEF.md
# Branch Target and Delay-Slot Sequencer

This block owns the fetch address of a processor that mixes 2-byte and 4-byte instructions. Each time the decoder retires an instruction it raises `step_i` together with the instruction's length, its decoded branch kind and its raw fields. The block works out whether the instruction is a branch that is taken and where it goes. It then loads the next fetch address, and for branch-and-link kinds it produces the return address with a one-cycle write strobe.

Every branch kind can be immediate or delayed. An immediate branch redirects fetch on the step that retires it. A delayed branch first lets the next sequential instruction (the slot) retire, and redirects fetch on that slot's step. The pending target is held internally. A branch that shows up in the slot is flagged on `err_o` and has no effect. There are four target forms: PC-relative long, PC-relative short, absolute, and register. Every form yields an even address. Conditional kinds test one condition-code bit against a chosen polarity.

Top module: `dslot_branch_unit`

## Requirements
- R1: In any cycle after a clock edge with `rst` high, `fetch_addr_o` equals `RESET_VEC` (default 0x1000), and `link_we_o` and `err_o` are 0. Reset also discards a pending delayed branch.
- R2: A step that is not a taken branch loads `fetch_addr_o` with the current address plus 2 when `short_i`=1 and plus 4 otherwise. In a cycle without `step_i`, `fetch_addr_o` holds and `link_we_o`/`err_o` are 0.
- R3: A taken branch with `delayed_i`=0 loads the target into `fetch_addr_o` at the edge of its step.
- R4: A taken branch with `delayed_i`=1 first loads the sequential address. At the next step, whatever its kind, `fetch_addr_o` takes the held target, and idle cycles in between have no effect.
- R5: The link kinds (`kind_i` 4, 5, 6) take the branch unconditionally. On their step they pulse `link_we_o` for one cycle. `link_val_o` is the sequential address when immediate and the sequential address plus 4 when delayed.
- R6: Relative long targets (`kind_i` 2 and 5) are current address + ((sign-extended `fb_i`) × 2^17 + `imm_i` × 2), modulo 2^ADDR_W.
- R7: The absolute target (`kind_i` 4) is `fa_i`×2^20 + `fb_i`×2^16 + `imm_i` with bit 0 cleared.
- R8: Register targets (`kind_i` 3 and 6) are `reg_op_i` with bit 0 cleared. `fetch_addr_o` bit 0 is never 1.
- R9: Conditional long kinds (`kind_i` 2 relative, 3 register) are taken exactly when `cc_i[16 + fa_i]` equals `pol_set_i`.
- R10: The short jump (`kind_i` 1) is taken exactly when `cc_i[24 + sub_op_i[2:0]]` equals `sub_op_i[3]`. Its target is the current address + (sign-extended `fa_i`) × 32 + `fb_i` × 2.
- R11: A short jump with `sub_op_i`, `fa_i` and `fb_i` all zero is a no-op. It advances by its length and is not counted as a branch when it occupies a delay slot.
- R12: A branch kind other than 0 or the no-op, retired in a delay slot, pulses `err_o` for one cycle. Its target and link write are discarded, and the pending target is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | An instruction retires this cycle |
| short_i | input | 1 | Retiring instruction is 2 bytes (else 4) |
| kind_i | input | 3 | Branch kind: 0 none, 1 short jump, 2 cond relative, 3 cond register, 4 link absolute, 5 link relative, 6 link register |
| delayed_i | input | 1 | Branch uses one delay slot |
| pol_set_i | input | 1 | Polarity for conditional long kinds (1: branch when bit set) |
| sub_op_i | input | 4 | Short jump sub-opcode: bit 3 polarity, bits 2:0 condition select |
| fa_i | input | 4 | A field |
| fb_i | input | 4 | B field |
| imm_i | input | 16 | Immediate field |
| reg_op_i | input | ADDR_W | Register operand for register targets |
| cc_i | input | CC_W | Condition-code word |
| fetch_addr_o | output | ADDR_W | Address of the instruction to fetch next (also the current address) |
| link_val_o | output | ADDR_W | Return address for link kinds |
| link_we_o | output | 1 | One-cycle link write strobe |
| err_o | output | 1 | Branch seen in a delay slot |

## Verification
The hardest situation to reach from the ports is a delay slot that holds something other than a plain instruction. Examples are a second branch, a link branch whose write must be suppressed, a no-op jump that must not be flagged, and a reset arriving while a target is pending. The bench first issues a taken delayed branch and sometimes inserts idle cycles. It then retires each branch kind, the no-op and a reset in the slot. A running address model in the bench is carried across all sweeps, so every redirect is checked against the address it started from.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  typedef enum logic [2:0] {
    BK_NONE    = 3'd0,
    BK_JUMP    = 3'd1,
    BK_CBR_REL = 3'd2,
    BK_CBR_REG = 3'd3,
    BK_LNK_ABS = 3'd4,
    BK_LNK_REL = 3'd5,
    BK_LNK_REG = 3'd6
  } br_kind_e;

  localparam int KIND_W    = 3;
  localparam int SHORT_LEN = 2;
  localparam int LONG_LEN  = 4;
  localparam int SLOT_LEN  = 4;
  localparam int FLD_W     = 4;
  localparam int IMM_W     = 16;
endpackage

// File: rtl/dslot_target_gen.sv
module dslot_target_gen
  import dslot_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  br_kind_e           kind,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [FLD_W-1:0]   fa,
  input  logic [FLD_W-1:0]   fb,
  input  logic [IMM_W-1:0]   imm,
  input  logic [ADDR_W-1:0]  reg_op,
  output logic [ADDR_W-1:0]  tgt
);
  localparam int OFF_W    = 32;
  localparam int LONG_EXT = OFF_W - FLD_W - IMM_W - 1;
  localparam int JUMP_EXT = OFF_W - 2 * FLD_W - 1;

  logic signed [OFF_W-1:0] off_long;
  logic signed [OFF_W-1:0] off_jump;
  logic        [OFF_W-1:0] abs_word;
  logic        [ADDR_W-1:0] reg_even;

  always_comb begin
    off_long = {{LONG_EXT{fb[FLD_W-1]}}, fb, imm, 1'b0};
    off_jump = {{JUMP_EXT{fa[FLD_W-1]}}, fa, fb, 1'b0};
    abs_word = {8'h00, fa, fb, imm} & ~32'd1;
    reg_even = reg_op & ~ADDR_W'(1);
  end

  always_comb begin
    unique case (kind)
      BK_JUMP:                tgt = pc + ADDR_W'(off_jump);
      BK_CBR_REL, BK_LNK_REL: tgt = pc + ADDR_W'(off_long);
      BK_LNK_ABS:             tgt = ADDR_W'(abs_word);
      BK_CBR_REG, BK_LNK_REG: tgt = reg_even;
      default:                tgt = pc;
    endcase
  end
endmodule

// File: rtl/dslot_cond_eval.sv
module dslot_cond_eval
  import dslot_pkg::*;
#(
  parameter int CC_W    = 32,
  parameter int LC_BASE = 16,
  parameter int JC_BASE = 24
) (
  input  br_kind_e          kind,
  input  logic [FLD_W-1:0]  fa,
  input  logic [FLD_W-1:0]  fb,
  input  logic [FLD_W-1:0]  sub_op,
  input  logic              pol_set,
  input  logic [CC_W-1:0]   cc,
  output logic              taken,
  output logic              is_branch,
  output logic              is_link
);
  localparam int IDX_W = $clog2(CC_W);

  logic [IDX_W-1:0] long_idx;
  logic [IDX_W-1:0] jump_idx;
  logic             jump_nop;

  always_comb begin
    long_idx  = IDX_W'(LC_BASE) + IDX_W'(fa);
    jump_idx  = IDX_W'(JC_BASE) + IDX_W'(sub_op[2:0]);
    jump_nop  = (kind == BK_JUMP) && (sub_op == '0) && (fa == '0) && (fb == '0);
    is_branch = (kind != BK_NONE) && !jump_nop;
    is_link   = (kind == BK_LNK_ABS) || (kind == BK_LNK_REL) || (kind == BK_LNK_REG);
  end

  always_comb begin
    unique case (kind)
      BK_JUMP:                taken = !jump_nop && (cc[jump_idx] == sub_op[3]);
      BK_CBR_REL, BK_CBR_REG: taken = (cc[long_idx] == pol_set);
      BK_LNK_ABS, BK_LNK_REL,
      BK_LNK_REG:             taken = 1'b1;
      default:                taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/dslot_seq_ctl.sv
module dslot_seq_ctl
  import dslot_pkg::*;
#(
  parameter int                 ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]  RESET_VEC = 'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              short_i,
  input  logic              delayed_i,
  input  logic              taken_i,
  input  logic              is_branch_i,
  input  logic              is_link_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [ADDR_W-1:0] link_val_o,
  output logic              link_we_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] fetch_q, ptgt_q, link_q, seq;
  logic              pend_q, link_we_q, err_q;

  always_comb begin
    seq = fetch_q + (short_i ? ADDR_W'(SHORT_LEN) : ADDR_W'(LONG_LEN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q   <= RESET_VEC;
      ptgt_q    <= '0;
      pend_q    <= 1'b0;
      link_q    <= '0;
      link_we_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      link_we_q <= 1'b0;
      err_q     <= 1'b0;
      if (step_i) begin
        if (pend_q) begin
          fetch_q <= ptgt_q;
          pend_q  <= 1'b0;
          err_q   <= is_branch_i;
        end else begin
          if (is_link_i) begin
            link_we_q <= 1'b1;
            link_q    <= delayed_i ? seq + ADDR_W'(SLOT_LEN) : seq;
          end
          if (taken_i && delayed_i) begin
            fetch_q <= seq;
            pend_q  <= 1'b1;
            ptgt_q  <= tgt_i;
          end else if (taken_i) begin
            fetch_q <= tgt_i;
          end else begin
            fetch_q <= seq;
          end
        end
      end
    end
  end

  assign fetch_addr_o = fetch_q;
  assign link_val_o   = link_q;
  assign link_we_o    = link_we_q;
  assign err_o        = err_q;
endmodule

// File: rtl/dslot_branch_unit.sv
module dslot_branch_unit
  import dslot_pkg::*;
#(
  parameter int                 ADDR_W    = 32,
  parameter int                 CC_W      = 32,
  parameter int                 LC_BASE   = 16,
  parameter int                 JC_BASE   = 24,
  parameter logic [ADDR_W-1:0]  RESET_VEC = 'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              short_i,
  input  logic [2:0]        kind_i,
  input  logic              delayed_i,
  input  logic              pol_set_i,
  input  logic [3:0]        sub_op_i,
  input  logic [3:0]        fa_i,
  input  logic [3:0]        fb_i,
  input  logic [15:0]       imm_i,
  input  logic [ADDR_W-1:0] reg_op_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [ADDR_W-1:0] link_val_o,
  output logic              link_we_o,
  output logic              err_o
);
  br_kind_e          kind;
  logic [ADDR_W-1:0] tgt;
  logic              taken, is_branch, is_link;

  assign kind = br_kind_e'(kind_i);

  dslot_target_gen #(.ADDR_W(ADDR_W)) u_tgt (
    .kind(kind), .pc(fetch_addr_o), .fa(fa_i), .fb(fb_i),
    .imm(imm_i), .reg_op(reg_op_i), .tgt(tgt)
  );

  dslot_cond_eval #(.CC_W(CC_W), .LC_BASE(LC_BASE), .JC_BASE(JC_BASE)) u_cond (
    .kind(kind), .fa(fa_i), .fb(fb_i), .sub_op(sub_op_i), .pol_set(pol_set_i),
    .cc(cc_i), .taken(taken), .is_branch(is_branch), .is_link(is_link)
  );

  dslot_seq_ctl #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_seq (
    .clk(clk), .rst(rst), .step_i(step_i), .short_i(short_i),
    .delayed_i(delayed_i), .taken_i(taken), .is_branch_i(is_branch),
    .is_link_i(is_link), .tgt_i(tgt), .fetch_addr_o(fetch_addr_o),
    .link_val_o(link_val_o), .link_we_o(link_we_o), .err_o(err_o)
  );
endmodule

// File: rtl/dslot_branch_unit_chk.sv
module dslot_branch_unit_chk #(
  parameter int                 ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]  RESET_VEC = 'h1000
) (
  input logic              clk,
  input logic              rst,
  input logic              step_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              link_we_o,
  input logic              err_o
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fetch_addr_o == RESET_VEC && !link_we_o && !err_o));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> ($stable(fetch_addr_o) && !link_we_o && !err_o));

  assert_link_after_step_R5: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> $past(step_i));

  assert_even_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    !fetch_addr_o[0]);

  assert_slot_err_no_link_R12: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !link_we_o);
endmodule

bind dslot_branch_unit dslot_branch_unit_chk #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst(rst), .step_i(step_i), .fetch_addr_o(fetch_addr_o),
  .link_we_o(link_we_o), .err_o(err_o)
);

// File: tb/sim_dslot_branch_unit.sv
module sim_dslot_branch_unit;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        step_i = 0, short_i = 0, delayed_i = 0, pol_set_i = 0;
  logic [2:0]  kind_i = 0;
  logic [3:0]  sub_op_i = 0, fa_i = 0, fb_i = 0;
  logic [15:0] imm_i = 0;
  logic [31:0] reg_op_i = 0, cc_i = 0;
  logic [31:0] fetch_addr_o, link_val_o;
  logic        link_we_o, err_o;

  dslot_branch_unit u0 (
    .clk(clk), .rst(rst), .step_i(step_i), .short_i(short_i), .kind_i(kind_i),
    .delayed_i(delayed_i), .pol_set_i(pol_set_i), .sub_op_i(sub_op_i),
    .fa_i(fa_i), .fb_i(fb_i), .imm_i(imm_i), .reg_op_i(reg_op_i), .cc_i(cc_i),
    .fetch_addr_o(fetch_addr_o), .link_val_o(link_val_o),
    .link_we_o(link_we_o), .err_o(err_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_fetch, m_ptgt, m_link;
  bit m_pend, m_we, m_err;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sx4(input logic [3:0] v);
    return v[3] ? int'(v) - 16 : int'(v);
  endfunction

  task automatic model_step(input bit st);
    logic [31:0] seq, tgt;
    bit nop, isbr, tk;
    m_we = 0; m_err = 0;
    if (!st) return;
    seq  = m_fetch + (short_i ? 32'd2 : 32'd4);
    nop  = (kind_i == 1) && (sub_op_i == 0) && (fa_i == 0) && (fb_i == 0);
    isbr = (kind_i != 0) && !nop;
    if (m_pend) begin
      m_err = isbr; m_fetch = m_ptgt; m_pend = 0;
      return;
    end
    tk = 0; tgt = 0;
    case (kind_i)
      3'd1: begin tgt = m_fetch + 32'(sx4(fa_i) * 32 + int'(fb_i) * 2);
                  tk = !nop && (cc_i[24 + int'(sub_op_i[2:0])] == sub_op_i[3]); end
      3'd2: begin tgt = m_fetch + 32'(sx4(fb_i) * 131072 + int'(imm_i) * 2);
                  tk = (cc_i[16 + int'(fa_i)] == pol_set_i); end
      3'd3: begin tgt = reg_op_i & ~32'd1; tk = (cc_i[16 + int'(fa_i)] == pol_set_i); end
      3'd4: begin tgt = (32'(fa_i) * 32'h10_0000 + 32'(fb_i) * 32'h1_0000 + 32'(imm_i)) & ~32'd1; tk = 1; end
      3'd5: begin tgt = m_fetch + 32'(sx4(fb_i) * 131072 + int'(imm_i) * 2); tk = 1; end
      3'd6: begin tgt = reg_op_i & ~32'd1; tk = 1; end
      default: ;
    endcase
    if (kind_i >= 4) begin
      m_we = 1;
      m_link = delayed_i ? seq + 32'd4 : seq;
    end
    if (tk && delayed_i) begin m_fetch = seq; m_pend = 1; m_ptgt = tgt; end
    else if (tk) m_fetch = tgt;
    else m_fetch = seq;
  endtask

  task automatic step(input string tag, input bit st = 1);
    step_i = st;
    model_step(st);
    @(posedge clk);
    @(negedge clk);
    step_i = 0;
    chk(tag, "fetch", fetch_addr_o, m_fetch);
    chk(tag, "link_we", 32'(link_we_o), 32'(m_we));
    chk(tag, "err", 32'(err_o), 32'(m_err));
    if (m_we) chk(tag, "link_val", link_val_o, m_link);
  endtask

  task automatic setf(input int k, input bit dly, input bit sh, input logic [3:0] a,
                      input logic [3:0] b, input logic [15:0] im);
    kind_i = 3'(k); delayed_i = dly; short_i = sh; fa_i = a; fb_i = b; imm_i = im;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R2 act=running exp=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] imms [5];
    logic [31:0] regs [4];
    imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'h7fff;
    imms[3] = 16'h8000; imms[4] = 16'hffff;
    regs[0] = 32'h1234_5679; regs[1] = 32'hffff_ffff;
    regs[2] = 32'h0000_0002; regs[3] = 32'h8000_0001;

    repeat (3) @(negedge clk);
    chk("R1", "fetch", fetch_addr_o, RV);
    chk("R1", "link_we", 32'(link_we_o), 0);
    chk("R1", "err", 32'(err_o), 0);
    rst = 0;
    m_fetch = RV; m_pend = 0; m_ptgt = 0; m_link = 0;

    // R2: sequential lengths and idle hold
    setf(0, 0, 1, 0, 0, 0); step("R2");
    setf(0, 0, 0, 0, 0, 0); step("R2");
    step("R2", 0);
    setf(0, 1, 1, 4'hf, 4'hf, 16'hffff); step("R2");

    // R6 / R3 / R5: relative long targets, immediate link
    for (int b = 0; b < 16; b++)
      for (int i = 0; i < 5; i++) begin
        setf(5, 0, 0, 4'(b), 4'(b), imms[i]); step("R6");
      end
    cc_i = 32'hffff_ffff; pol_set_i = 1;
    for (int b = 0; b < 16; b++) begin
      setf(2, 0, 0, 4'(b), 4'(b), 16'h0123); step("R3");
    end

    // R7: absolute targets
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        setf(4, 0, 0, 4'(a), 4'(b), 16'habcd); step("R7");
        setf(4, 0, 1, 4'(a), 4'(b), 16'h0342); step("R7");
      end

    // R8: register targets
    for (int i = 0; i < 4; i++) begin
      reg_op_i = regs[i];
      setf(6, 0, 0, 0, 0, 0); step("R8");
      setf(3, 0, 0, 4'(i), 0, 0); step("R8");
    end

    // R9: condition bit 16+A with both polarities
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++) begin
          cc_i = c ? 32'h5a3c_0f96 : ~32'h5a3c_0f96;
          pol_set_i = p[0];
          reg_op_i = 32'h0004_0000 + 32'(a * 8);
          setf(2, 0, 0, 4'(a), 4'h0, 16'h0008); step("R9");
          setf(3, 0, 1, 4'(a), 4'h0, 16'h0000); step("R9");
        end

    // R10: short jump condition and offset
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 16; a++) begin
          cc_i = c ? 32'h5a00_0000 : 32'ha5ff_ffff;
          sub_op_i = 4'(s);
          setf(1, 0, 1, 4'(a), 4'h5, 16'h0000); step("R10");
        end

    // R11: all-zero jump word is a no-op
    sub_op_i = 0; cc_i = 0;
    setf(1, 0, 1, 0, 0, 0); step("R11");
    setf(1, 0, 1, 0, 0, 0); step("R11");

    // R4 / R5: delayed branches with idle cycles before the slot
    for (int b = 0; b < 16; b++) begin
      setf(5, 1, 0, 0, 4'(b), 16'h0040); step("R4");
      step("R4", 0);
      setf(0, 0, b[0], 0, 0, 0); step("R4");
    end
    for (int i = 0; i < 4; i++) begin
      reg_op_i = regs[i];
      setf(6, 1, i[0], 0, 0, 0); step("R5");
      setf(0, 0, 0, 0, 0, 0); step("R5");
      setf(4, 0, 1, 4'(i), 4'h2, 16'h1000); step("R5");
    end

    // R11 in a slot: no error
    setf(4, 1, 0, 4'h1, 4'h0, 16'h2000); step("R11");
    sub_op_i = 0; setf(1, 0, 1, 0, 0, 0); step("R11");

    // R12: every branch kind in a delay slot
    cc_i = 32'hffff_ffff; pol_set_i = 1; reg_op_i = 32'h0000_9000;
    for (int k = 1; k < 7; k++)
      for (int d = 0; d < 2; d++) begin
        sub_op_i = 4'h8;
        setf(5, 1, 0, 0, 0, 16'h0100); step("R12");
        setf(k, d[0], 0, 4'h3, 4'h1, 16'h0400); step("R12");
        setf(0, 0, 0, 0, 0, 0); step("R12");
      end

    // R1: reset while a delayed target is pending
    setf(4, 1, 0, 4'h7, 4'h7, 16'h7770); step("R1");
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    chk("R1", "fetch", fetch_addr_o, RV);
    chk("R1", "link_we", 32'(link_we_o), 0);
    m_fetch = RV; m_pend = 0;
    setf(0, 0, 0, 0, 0, 0); step("R1");

    done = 1;
    report();
    $finish;
  end
endmodule